// File: doc/BRIEF.md
# I2C Controller Interrupt Status Unit

This block holds the interrupt state of an I2C master controller and exposes it through a small register read/write interface. The bus engine and the FIFOs signal conditions to it in two forms. Single-cycle event pulses set sticky raw status bits. Level conditions (transmit FIFO empty, receive FIFO full) are sampled and followed as they change. A mask register gates the raw status into a masked status word. The OR of that word drives one registered interrupt line.

Software clears sticky events by reading. Each sticky bit has its own clear address, and reading that address clears that bit alone. A bit that some other source sets in the meantime is therefore never lost. A combined clear address wipes every sticky bit at once.

The block also collects the causes of a transmit abort in a separate cause register. Software can read that register at any time. The cause register is wiped when the transmit-abort clear address is read. Every read returns its data one cycle after the request.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the raw status, mask, abort-cause register, `rd_data` and `irq` are all zero.
- R2: Interrupt bit positions: 0 rx underflow, 1 rx overflow, 2 rx full, 3 tx overflow, 4 tx empty, 5 read request, 6 tx abort, 7 rx done, 8 activity, 9 stop seen, 10 start seen, 11 general call. A pulse on `evt_pulse[b]` for a sticky bit (every bit except 2 and 4) sets raw bit b at the next clock edge. The bit stays set until it is cleared, and it never rises without such a pulse.
- R3: Raw bits 2 and 4 are level bits. Each one equals the corresponding `lvl_in` bit registered at the previous edge. Clear reads do not affect them, and their `evt_pulse` inputs are ignored.
- R4: A write to offset 0x30 loads `wdata[11:0]` into the mask. A read of 0x30 returns the mask, a read of 0x34 returns the raw status, and a read of 0x2C returns raw AND mask. Writing zero to the mask leaves the raw status unchanged.
- R5: The per-bit clear addresses are 0x44 + 4*k, where k counts the sticky bits in ascending order (bits 0,1,3,5,6,7,8,9,10,11 map to 0x44..0x68). Reading one of them returns the bit's value in bit 0 and clears only that bit. All other bits, and any events arriving in the same cycle, are kept.
- R6: A read of 0x40 returns the OR of all sticky raw bits in bit 0 and clears every sticky bit. Level bits are left alone.
- R7: When a set pulse and a clear read of the same bit occur in the same cycle, the bit ends set.
- R8: Abort causes `cause_pulse[12:0]` are ORed into the cause register, which reads at 0x80. Cause bit positions: 0 7-bit address NACK, 1 first 10-bit address byte NACK, 2 second 10-bit address byte NACK, 3 data NACK, 4 general-call NACK, 5 read after general call, 7 start byte acknowledged, 9 start byte with restart disabled, 10 10-bit read with restart disabled, 11 transfer while disabled, 12 arbitration lost. A read of the tx-abort clear address 0x54 wipes the register. A cause arriving in that same cycle is kept.
- R9: `irq` is a register holding the OR of raw AND mask as they stood one cycle earlier.
- R10: `rd_data` is registered: it carries the value for a read issued in the previous cycle and is zero after a cycle with no read. Unmapped addresses read zero. Writes to any address other than 0x30 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Register read request |
| wr_en | input | 1 | Register write request |
| addr | input | ADDR_W (8) | Byte offset of the access |
| wdata | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Read data, one cycle after `rd_en` |
| evt_pulse | input | N_INT (12) | Event pulses for the sticky bits |
| lvl_in | input | N_INT (12) | Level conditions for the level bits |
| cause_pulse | input | N_CAUSE (13) | Transmit-abort cause pulses |
| irq | output | 1 | Registered interrupt request |

## Verification
An event or level change drives its raw bit at the next edge, and `irq` reflects that raw bit one edge later. A mask write is visible to `irq` after two edges. A read's data and its clear effect both take effect at the edge that samples the request. The bench drives each stimulus at a falling edge. It samples `rd_data` and `irq` 1 ns after the following rising edge. Expected values are computed from the model state as it stood before that edge, so a read returns pre-clear data and `irq` follows the previous raw and mask.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

   // register map (byte offsets decoded by software)
   localparam int unsigned OFS_MSTAT    = 32'h2C;
   localparam int unsigned OFS_MASK     = 32'h30;
   localparam int unsigned OFS_RAW      = 32'h34;
   localparam int unsigned OFS_CLR_ALL  = 32'h40;
   localparam int unsigned OFS_CLR_BASE = 32'h44;
   localparam int unsigned OFS_STEP     = 4;
   localparam int unsigned OFS_CAUSE    = 32'h80;

   // interrupt bit positions
   localparam int unsigned B_RX_UNDER = 0;
   localparam int unsigned B_RX_OVER  = 1;
   localparam int unsigned B_RX_FULL  = 2;
   localparam int unsigned B_TX_OVER  = 3;
   localparam int unsigned B_TX_EMPTY = 4;
   localparam int unsigned B_RD_REQ   = 5;
   localparam int unsigned B_TX_ABORT = 6;
   localparam int unsigned B_RX_DONE  = 7;
   localparam int unsigned B_ACTIVITY = 8;
   localparam int unsigned B_STOP     = 9;
   localparam int unsigned B_START    = 10;
   localparam int unsigned B_GCALL    = 11;

   typedef struct packed {
      logic mstat;
      logic mask;
      logic raw;
      logic clr_all;
      logic cause;
   } rd_sel_t;

   // position of a sticky bit among the sticky bits below it
   function automatic int unsigned sticky_rank(input logic [63:0] lvl, input int unsigned b);
      int unsigned r;
      r = 0;
      for (int unsigned i = 0; i < b; i++)
         if (!lvl[i]) r++;
      return r;
   endfunction

   function automatic int unsigned clr_addr_of(input logic [63:0] lvl, input int unsigned b);
      return OFS_CLR_BASE + OFS_STEP * sticky_rank(lvl, b);
   endfunction

endpackage

// File: rtl/irq_bit_cell.sv
module irq_bit_cell #(
   parameter bit IS_LEVEL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic lvl_i,
   input  logic clr_i,
   output logic q_o
);

   generate
      if (IS_LEVEL) begin : g_level
         logic unused_level;
         assign unused_level = set_i ^ clr_i;
         always_ff @(posedge clk) begin
            if (!rst_n) q_o <= 1'b0;
            else        q_o <= lvl_i;
         end
      end else begin : g_sticky
         logic unused_sticky;
         assign unused_sticky = lvl_i;
         // a set in the clearing cycle keeps the bit
         always_ff @(posedge clk) begin
            if (!rst_n)     q_o <= 1'b0;
            else if (set_i) q_o <= 1'b1;
            else if (clr_i) q_o <= 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/irq_cause_reg.sv
module irq_cause_reg #(
   parameter int unsigned N_CAUSE = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_CAUSE-1:0] set_i,
   input  logic               wipe_i,
   output logic [N_CAUSE-1:0] q_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= (wipe_i ? '0 : q_o) | set_i;
   end

endmodule

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
   import irq_stat_pkg::*;
#(
   parameter int unsigned       ADDR_W     = 8,
   parameter int unsigned       N_INT      = 12,
   parameter logic [N_INT-1:0]  LEVEL_MASK = 12'h014,
   parameter int unsigned       ABORT_BIT  = 6
) (
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   output rd_sel_t           sel,
   output logic [N_INT-1:0]  bit_hit,
   output logic [N_INT-1:0]  clr_vec,
   output logic              mask_we,
   output logic              cause_wipe
);

   localparam logic [N_INT-1:0] STICKY = ~LEVEL_MASK;

   function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned ofs);
      return a == ADDR_W'(ofs);
   endfunction

   assign sel.mstat   = rd_en && at(addr, OFS_MSTAT);
   assign sel.mask    = rd_en && at(addr, OFS_MASK);
   assign sel.raw     = rd_en && at(addr, OFS_RAW);
   assign sel.clr_all = rd_en && at(addr, OFS_CLR_ALL);
   assign sel.cause   = rd_en && at(addr, OFS_CAUSE);
   assign mask_we     = wr_en && at(addr, OFS_MASK);

   genvar b;
   generate
      for (b = 0; b < N_INT; b++) begin : g_hit
         if (LEVEL_MASK[b]) begin : g_none
            assign bit_hit[b] = 1'b0;
         end else begin : g_clr
            localparam int unsigned CA = clr_addr_of(64'(LEVEL_MASK), b);
            assign bit_hit[b] = rd_en && at(addr, CA);
         end
      end
   endgenerate

   assign clr_vec    = bit_hit | ({N_INT{sel.clr_all}} & STICKY);
   assign cause_wipe = bit_hit[ABORT_BIT];

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
   import irq_stat_pkg::*;
#(
   parameter int unsigned      DATA_W     = 32,
   parameter int unsigned      N_INT      = 12,
   parameter int unsigned      N_CAUSE    = 13,
   parameter logic [N_INT-1:0] LEVEL_MASK = 12'h014
) (
   input  logic               clk,
   input  logic               rst_n,
   input  rd_sel_t            sel,
   input  logic [N_INT-1:0]   bit_hit,
   input  logic [N_INT-1:0]   raw,
   input  logic [N_INT-1:0]   mask,
   input  logic [N_CAUSE-1:0] cause,
   output logic [DATA_W-1:0]  rd_data
);

   localparam logic [N_INT-1:0] STICKY = ~LEVEL_MASK;

   logic [DATA_W-1:0] nxt;

   // address selects are disjoint, so the terms simply OR together
   always_comb begin
      nxt = '0;
      if (sel.mstat)   nxt = nxt | DATA_W'(raw & mask);
      if (sel.mask)    nxt = nxt | DATA_W'(mask);
      if (sel.raw)     nxt = nxt | DATA_W'(raw);
      if (sel.cause)   nxt = nxt | DATA_W'(cause);
      if (sel.clr_all) nxt[0] = nxt[0] | (|(raw & STICKY));
      if (|bit_hit)    nxt[0] = nxt[0] | (|(raw & bit_hit));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_data <= '0;
      else        rd_data <= nxt;
   end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
   import irq_stat_pkg::*;
#(
   parameter int unsigned      ADDR_W     = 8,
   parameter int unsigned      DATA_W     = 32,
   parameter int unsigned      N_INT      = 12,
   parameter int unsigned      N_CAUSE    = 13,
   parameter logic [N_INT-1:0] LEVEL_MASK = 12'h014,
   parameter int unsigned      ABORT_BIT  = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [N_INT-1:0]   evt_pulse,
   input  logic [N_INT-1:0]   lvl_in,
   input  logic [N_CAUSE-1:0] cause_pulse,
   output logic               irq
);

   localparam int unsigned N_STICKY  = N_INT - $countones(LEVEL_MASK);
   localparam int unsigned CLR_LIMIT = OFS_CLR_BASE + OFS_STEP * N_STICKY;

   // elaboration-time parameter checks
   generate
      if (N_INT > DATA_W || N_CAUSE > DATA_W) begin : g_err_width
         $error("interrupt or cause vector wider than the data bus");
      end
      if (ABORT_BIT >= N_INT) begin : g_err_abort_range
         $error("abort bit index out of range");
      end
      if (((LEVEL_MASK >> ABORT_BIT) & 1'b1) != 0) begin : g_err_abort_level
         $error("abort bit must be a sticky bit");
      end
      if (CLR_LIMIT > OFS_CAUSE) begin : g_err_overlap
         $error("per-bit clear block runs into the cause register");
      end
      if ((64'd1 << ADDR_W) <= 64'(OFS_CAUSE)) begin : g_err_addr
         $error("address width too small for the register map");
      end
      if (DATA_W > N_INT) begin : g_wdata_hi
         logic unused_wdata_hi;
         assign unused_wdata_hi = ^wdata[DATA_W-1:N_INT];
      end
   endgenerate

   rd_sel_t            sel;
   logic [N_INT-1:0]   bit_hit;
   logic [N_INT-1:0]   clr_vec;
   logic               mask_we;
   logic               cause_wipe;
   logic [N_INT-1:0]   raw_q;
   logic [N_INT-1:0]   mask_q;
   logic [N_CAUSE-1:0] cause_q;

   irq_addr_dec #(
      .ADDR_W    (ADDR_W),
      .N_INT     (N_INT),
      .LEVEL_MASK(LEVEL_MASK),
      .ABORT_BIT (ABORT_BIT)
   ) u_dec (
      .rd_en     (rd_en),
      .wr_en     (wr_en),
      .addr      (addr),
      .sel       (sel),
      .bit_hit   (bit_hit),
      .clr_vec   (clr_vec),
      .mask_we   (mask_we),
      .cause_wipe(cause_wipe)
   );

   genvar b;
   generate
      for (b = 0; b < N_INT; b++) begin : g_bit
         irq_bit_cell #(
            .IS_LEVEL(LEVEL_MASK[b])
         ) u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(evt_pulse[b]),
            .lvl_i(lvl_in[b]),
            .clr_i(clr_vec[b]),
            .q_o  (raw_q[b])
         );
      end
   endgenerate

   irq_cause_reg #(
      .N_CAUSE(N_CAUSE)
   ) u_cause (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (cause_pulse),
      .wipe_i(cause_wipe),
      .q_o   (cause_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_we) mask_q <= wdata[N_INT-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(raw_q & mask_q);
   end

   irq_read_mux #(
      .DATA_W    (DATA_W),
      .N_INT     (N_INT),
      .N_CAUSE   (N_CAUSE),
      .LEVEL_MASK(LEVEL_MASK)
   ) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel),
      .bit_hit(bit_hit),
      .raw    (raw_q),
      .mask   (mask_q),
      .cause  (cause_q),
      .rd_data(rd_data)
   );

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk #(
   parameter int unsigned      N_INT      = 12,
   parameter int unsigned      N_CAUSE    = 13,
   parameter logic [N_INT-1:0] LEVEL_MASK = 12'h014
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N_INT-1:0]   evt_pulse,
   input logic [N_INT-1:0]   lvl_in,
   input logic [N_CAUSE-1:0] cause_pulse,
   input logic [N_INT-1:0]   raw,
   input logic [N_INT-1:0]   mask,
   input logic [N_CAUSE-1:0] cause,
   input logic [N_INT-1:0]   clr_vec,
   input logic               cause_wipe,
   input logic               irq
);

   localparam logic [N_INT-1:0] STICKY = ~LEVEL_MASK;

   AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((raw & STICKY & $past(evt_pulse)) == (STICKY & $past(evt_pulse)))); // R7
   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((raw & ~$past(raw) & STICKY & ~$past(evt_pulse)) == '0)); // R2
   AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((raw & LEVEL_MASK) == ($past(lvl_in) & LEVEL_MASK))); // R3
   AST_CLEAR_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (($past(raw) & ~$past(clr_vec) & STICKY & ~raw) == '0)); // R5
   AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |=> !irq); // R4
   AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(raw & mask)) |=> irq); // R9
   AST_CAUSE_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
      (cause_wipe && (cause_pulse == '0)) |=> (cause == '0)); // R8
   AST_CAUSE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cause_wipe |=> ((cause & $past(cause)) == $past(cause))); // R8

endmodule

bind irq_status_unit irq_status_chk #(
   .N_INT     (N_INT),
   .N_CAUSE   (N_CAUSE),
   .LEVEL_MASK(LEVEL_MASK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_pulse  (evt_pulse),
   .lvl_in     (lvl_in),
   .cause_pulse(cause_pulse),
   .raw        (raw_q),
   .mask       (mask_q),
   .cause      (cause_q),
   .clr_vec    (clr_vec),
   .cause_wipe (cause_wipe),
   .irq        (irq)
);

// File: tb/irq_status_unit_bench.sv
`timescale 1ns/1ps
module irq_status_unit_bench;

   localparam logic [11:0] LVL    = 12'h014;
   localparam logic [11:0] STICKY = 12'hFEB;
   localparam int SLIST [10] = '{0, 1, 3, 5, 6, 7, 8, 9, 10, 11};
   localparam logic [7:0] ADDRS [17] = '{8'h2C, 8'h30, 8'h34, 8'h40, 8'h44, 8'h48, 8'h4C,
      8'h50, 8'h54, 8'h58, 8'h5C, 8'h60, 8'h64, 8'h68, 8'h80, 8'h3C, 8'h84};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rd_data;
   logic [11:0] evt_pulse = '0;
   logic [11:0] lvl_in = '0;
   logic [12:0] cause_pulse = '0;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;

   logic [11:0] m_raw = '0;
   logic [11:0] m_mask = '0;
   logic [12:0] m_cause = '0;

   always #2.5 clk = ~clk;

   irq_status_unit u_irq_status_unit (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .rd_data(rd_data), .evt_pulse(evt_pulse), .lvl_in(lvl_in),
      .cause_pulse(cause_pulse), .irq(irq)
   );

   function automatic logic [31:0] exp_read(input logic [7:0] a, input logic [11:0] r,
                                            input logic [11:0] m, input logic [12:0] c);
      logic [31:0] v;
      v = '0;
      case (a)
         8'h2C: v = {20'd0, r & m};
         8'h30: v = {20'd0, m};
         8'h34: v = {20'd0, r};
         8'h40: v = {31'd0, |(r & STICKY)};
         8'h80: v = {19'd0, c};
         default: begin
            for (int k = 0; k < 10; k++)
               if (a == 8'(8'h44 + 4 * k)) v = {31'd0, r[SLIST[k]]};
         end
      endcase
      return v;
   endfunction

   function automatic logic [11:0] clr_of(input logic rd, input logic [7:0] a);
      logic [11:0] c;
      c = '0;
      if (rd) begin
         if (a == 8'h40) c = STICKY;
         for (int k = 0; k < 10; k++)
            if (a == 8'(8'h44 + 4 * k)) c[SLIST[k]] = 1'b1;
      end
      return c;
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic rd, input logic wr, input logic [7:0] a,
                       input logic [31:0] wd, input logic [11:0] ev, input logic [11:0] lv,
                       input logic [12:0] cp, input string tag);
      logic [31:0] e_rd;
      logic        e_irq;
      @(negedge clk);
      rd_en = rd; wr_en = wr; addr = a; wdata = wd;
      evt_pulse = ev; lvl_in = lv; cause_pulse = cp;
      e_rd  = rd ? exp_read(a, m_raw, m_mask, m_cause) : 32'd0;
      e_irq = |(m_raw & m_mask);
      m_raw = (((m_raw & ~clr_of(rd, a)) | ev) & STICKY) | (lv & LVL);
      if (wr && a == 8'h30) m_mask = wd[11:0];
      m_cause = ((rd && a == 8'h54) ? 13'd0 : m_cause) | cp;
      @(posedge clk);
      #1;
      chk(tag, "rd_data", rd_data, e_rd);
      chk(tag, "irq", {31'd0, irq}, {31'd0, e_irq});
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      step(1'b1, 1'b0, a, 32'd0, 12'd0, lvl_in, 13'd0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R0 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0]  ra;
      logic [31:0] seed;
      seed = $urandom(32'h5EED_1234);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "rd_data in reset", rd_data, 32'd0);
      chk("R1", "irq in reset", {31'd0, irq}, 32'd0);
      rst_n = 1'b1;
      rd(8'h34, "R1");
      rd(8'h30, "R1");
      rd(8'h80, "R1");

      // R2: sticky set and hold
      step(1'b0, 1'b0, 8'h00, 0, 12'h200, 12'h000, 13'd0, "R2");
      rd(8'h34, "R2");
      rd(8'h34, "R2");
      // R3: level bits follow source, immune to clears and pulses
      step(1'b0, 1'b0, 8'h00, 0, 12'h004, 12'h010, 13'd0, "R3");
      step(1'b1, 1'b0, 8'h40, 0, 12'h000, 12'h010, 13'd0, "R3");
      rd(8'h34, "R3");
      step(1'b1, 1'b0, 8'h34, 0, 12'h000, 12'h004, 13'd0, "R3");
      rd(8'h34, "R3");
      // R4 / R9: mask, masked status, irq
      step(1'b0, 1'b0, 8'h00, 0, 12'h841, 12'h004, 13'd0, "R4");
      step(1'b0, 1'b1, 8'h30, 32'hFFFF_F041, 12'h000, 12'h004, 13'd0, "R4");
      rd(8'h30, "R4");
      rd(8'h2C, "R9");
      step(1'b0, 1'b1, 8'h30, 32'h0, 12'h000, 12'h004, 13'd0, "R4");
      rd(8'h34, "R4");
      rd(8'h2C, "R9");
      // R5: per-bit clear, other bits and concurrent events kept
      step(1'b0, 1'b1, 8'h30, 32'hFFF, 12'h000, 12'h004, 13'd0, "R5");
      step(1'b1, 1'b0, 8'h54, 0, 12'h002, 12'h004, 13'd0, "R5");
      rd(8'h34, "R5");
      rd(8'h54, "R5");
      rd(8'h44, "R5");
      rd(8'h34, "R5");
      // R7: set wins over same-cycle clear of bit 9 (address 0x60)
      step(1'b1, 1'b0, 8'h60, 0, 12'h200, 12'h000, 13'd0, "R7");
      rd(8'h34, "R7");
      // R6: combined clear
      step(1'b0, 1'b0, 8'h00, 0, 12'hFFF, 12'h014, 13'd0, "R6");
      rd(8'h40, "R6");
      rd(8'h34, "R6");
      // R8: abort cause capture and wipe
      step(1'b0, 1'b0, 8'h00, 0, 12'h040, 12'h000, 13'h1089, "R8");
      rd(8'h80, "R8");
      step(1'b1, 1'b0, 8'h54, 0, 12'h000, 12'h000, 13'h0000, "R8");
      rd(8'h80, "R8");
      step(1'b0, 1'b0, 8'h00, 0, 12'h000, 12'h000, 13'h0800, "R8");
      step(1'b1, 1'b0, 8'h54, 0, 12'h000, 12'h000, 13'h0002, "R8");
      rd(8'h80, "R8");
      // R10: unmapped reads, stray writes, idle cycles
      rd(8'h3C, "R10");
      step(1'b0, 1'b1, 8'h34, 32'hFFF, 12'h000, 12'h000, 13'd0, "R10");
      step(1'b0, 1'b1, 8'h80, 32'hFFF, 12'h000, 12'h000, 13'd0, "R10");
      rd(8'h30, "R10");
      step(1'b0, 1'b0, 8'h30, 0, 12'h000, 12'h000, 13'd0, "R10");

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         r  = $urandom % 20;
         ra = (r < 17) ? ADDRS[r] : 8'($urandom);
         step(($urandom % 3) != 0, ($urandom % 8) == 0, ra, $urandom,
              12'($urandom & $urandom & $urandom), 12'($urandom),
              13'($urandom & $urandom & $urandom & $urandom), "random");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule